// File: doc/BRIEF.md
# Dual-Group Manchester Packet Transmitter

This block drives eight serial lanes with Manchester-coded packets. The lanes form two groups of four. Every lane in a group carries the same waveform, and each group has its own idle spacing between packets. A single trigger input asks for a new packet. Each group that is free, or is in the final cycle of its current packet or gap, accepts the trigger and starts sending on the next clock edge.

A packet has three fields: a 4-bit start pattern, a shared sequence number, and a checksum. The sequence counter is common to both groups. Groups that accept the same trigger therefore send identical numbers, and the counter advances once for each trigger that at least one group accepts. Each half of a bit period lasts one clock cycle. The block clock therefore runs at twice the line bit rate, for example 100 MHz for 50 Mbit/s per lane.

The spacing value of a group is captured only when that group accepts a trigger. A value written while a packet or gap is running affects only the next packet. A spacing of zero, with the trigger held high, gives packets with no idle half-bit between them.

Top module: `mlane_pkt_tx`

## Requirements
- R1: While reset is high and on the first cycle after it, all eight lanes and both busy bits are low.
- R2: A 1 bit is sent as low for one cycle followed by high for one cycle. A 0 bit is sent as high then low. An idle lane is held low.
- R3: A packet is sent MSB first and has three fields in this order: the start pattern 1010, the 32-bit sequence number, and an 8-bit checksum equal to the XOR of the four bytes of the sequence number. Its first half-bit appears on the lanes after the second rising edge at which the trigger is seen high.
- R4: The sequence number is 0 for the first packet after reset. It increases by one for each trigger accepted by either group or both. Groups that accept the same trigger carry the same number.
- R5: lane_o[3:0] form group A, which is spaced by gap_a. lane_o[7:4] form group B, which is spaced by gap_b. All four lanes of a group are identical on every cycle.
- R6: After a packet, a group's lanes stay low for twice its spacing value in cycles, and its busy bit stays high through this gap. A trigger that arrives while the group is busy and not in its last cycle is ignored.
- R7: With a spacing of zero and the trigger held high, the next packet begins on the cycle right after the last half-bit of the previous one.
- R8: The spacing is captured when the trigger is accepted. Changes during a packet or gap do not alter that packet's gap.
- R9: A group's busy bit goes high after the edge that accepts a trigger. It goes low after the final packet or gap cycle, unless a new trigger is accepted at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one cycle per Manchester half-bit |
| rst | input | 1 | Synchronous active-high reset |
| pkt_start | input | 1 | Packet request shared by both groups |
| gap_a | input | GAP_W | Group A idle spacing in bit periods |
| gap_b | input | GAP_W | Group B idle spacing in bit periods |
| lane_o | output | 2*GRP_LANES | Encoded lanes; low half is group A |
| busy_o | output | 2 | Per-group busy, bit 0 is group A |

## Verification
The assertions check several properties on every cycle. The lanes of a group always agree. An idle group's lanes fall low one cycle after busy drops. The lane level always flips at mid-bit. The shared counter changes only on an accepted trigger. A group that is busy and not in its last cycle stays busy. The captured spacing holds steady while a group is busy. The bench's reference model covers what the assertions cannot: exact bit order and checksum content, gap length, back-to-back joining, and counter sharing when the two groups accept triggers at different times.

// File: rtl/mlane_pkg.sv
package mlane_pkg;
  localparam int SYNC_W = 4;
  localparam logic [SYNC_W-1:0] SYNC_PAT = 4'b1010;
  localparam int CHK_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_GAP  = 2'd2
  } grp_st_e;
endpackage

// File: rtl/mlane_seq_ctr.sv
module mlane_seq_ctr #(
  parameter int SEQ_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [SEQ_W-1:0] seq
);
  always_ff @(posedge clk) begin
    if (rst) seq <= '0;
    else if (inc) seq <= seq + SEQ_W'(1);
  end

  // R4: counter moves by exactly one per accepted trigger
  p_seq_step_r4: assert property (@(posedge clk) disable iff (rst)
    inc |=> (seq == $past(seq) + SEQ_W'(1)));
  p_seq_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(seq));
endmodule

// File: rtl/mlane_grp_fsm.sv
module mlane_grp_fsm
  import mlane_pkg::*;
#(
  parameter int SEQ_W = 32,
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [GAP_W-1:0] gap_in,
  input  logic [SEQ_W-1:0] seq_in,
  output logic             accept,
  output logic             busy,
  output logic             tx_on,
  output logic             tx_bit,
  output logic             tx_half
);
  localparam int PKT_W  = SYNC_W + SEQ_W + CHK_W;
  localparam int IDX_W  = $clog2(PKT_W);
  localparam int GCNT_W = GAP_W + 1;
  localparam int NBYTE  = SEQ_W / 8;

  grp_st_e           st;
  logic [PKT_W-1:0]  sh;
  logic [IDX_W-1:0]  idx;
  logic              half;
  logic [GAP_W-1:0]  gap_q;
  logic [GCNT_W-1:0] gcnt;
  logic [CHK_W-1:0]  xs;
  logic              last_bit;
  logic              done_now;

  always_comb begin
    xs = '0;
    for (int i = 0; i < NBYTE; i++) xs = xs ^ seq_in[i*8 +: 8];
  end

  assign last_bit = (idx == IDX_W'(PKT_W - 1));
  assign done_now = ((st == ST_SEND) && half && last_bit && (gap_q == '0)) ||
                    ((st == ST_GAP) && (gcnt == '0));
  assign accept   = start && ((st == ST_IDLE) || done_now);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      sh    <= '0;
      idx   <= '0;
      half  <= 1'b0;
      gap_q <= '0;
      gcnt  <= '0;
    end else if (accept) begin
      st    <= ST_SEND;
      sh    <= {SYNC_PAT, seq_in, xs};
      idx   <= '0;
      half  <= 1'b0;
      gap_q <= gap_in;
    end else begin
      case (st)
        ST_SEND: begin
          if (!half) begin
            half <= 1'b1;
          end else begin
            half <= 1'b0;
            if (last_bit) begin
              if (gap_q == '0) begin
                st <= ST_IDLE;
              end else begin
                st   <= ST_GAP;
                gcnt <= GCNT_W'({gap_q, 1'b0}) - GCNT_W'(1);
              end
            end else begin
              idx <= idx + IDX_W'(1);
              sh  <= sh << 1;
            end
          end
        end
        ST_GAP: begin
          if (gcnt == '0) st <= ST_IDLE;
          else gcnt <= gcnt - GCNT_W'(1);
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy    = (st != ST_IDLE);
  assign tx_on   = (st == ST_SEND);
  assign tx_bit  = sh[PKT_W-1];
  assign tx_half = half;

  // R6: a busy group that is not finishing cannot drop busy
  p_busy_hold_r6: assert property (@(posedge clk) disable iff (rst)
    ((st != ST_IDLE) && !done_now) |=> (st != ST_IDLE));
  // R8: captured spacing frozen until the next accepted trigger
  p_gap_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    ((st != ST_IDLE) && !accept) |=> $stable(gap_q));
endmodule

// File: rtl/mlane_man_enc.sv
module mlane_man_enc #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             on,
  input  logic             data,
  input  logic             half,
  output logic [LANES-1:0] lanes
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) lanes[l] <= 1'b0;
      else lanes[l] <= on ? (half ? data : ~data) : 1'b0;
    end
  end
endmodule

// File: rtl/mlane_pkt_tx.sv
module mlane_pkt_tx #(
  parameter int SEQ_W     = 32,
  parameter int GAP_W     = 8,
  parameter int GRP_LANES = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     pkt_start,
  input  logic [GAP_W-1:0]         gap_a,
  input  logic [GAP_W-1:0]         gap_b,
  output logic [2*GRP_LANES-1:0]   lane_o,
  output logic [1:0]               busy_o
);
  localparam int NGRP = 2;

  logic [GAP_W-1:0] gap_arr [NGRP];
  logic [SEQ_W-1:0] seq;
  logic [NGRP-1:0]  acc;
  logic [NGRP-1:0]  on_g, bit_g, half_g;

  assign gap_arr[0] = gap_a;
  assign gap_arr[1] = gap_b;

  mlane_seq_ctr #(.SEQ_W(SEQ_W)) u_seq (
    .clk(clk), .rst(rst), .inc(|acc), .seq(seq)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    mlane_grp_fsm #(.SEQ_W(SEQ_W), .GAP_W(GAP_W)) u_fsm (
      .clk(clk), .rst(rst), .start(pkt_start), .gap_in(gap_arr[g]),
      .seq_in(seq), .accept(acc[g]), .busy(busy_o[g]),
      .tx_on(on_g[g]), .tx_bit(bit_g[g]), .tx_half(half_g[g])
    );

    mlane_man_enc #(.LANES(GRP_LANES)) u_enc (
      .clk(clk), .rst(rst), .on(on_g[g]), .data(bit_g[g]),
      .half(half_g[g]), .lanes(lane_o[g*GRP_LANES +: GRP_LANES])
    );

    // R2: an idle group drives low on the following cycle
    p_idle_low_r2: assert property (@(posedge clk) disable iff (rst)
      !busy_o[g] |=> (lane_o[g*GRP_LANES +: GRP_LANES] == '0));
    // R2: every bit has a mid-bit transition
    p_mid_flip_r2: assert property (@(posedge clk) disable iff (rst)
      (on_g[g] && half_g[g]) |=>
        (lane_o[g*GRP_LANES] != $past(lane_o[g*GRP_LANES])));
    // R5: lanes of one group agree
    p_lanes_match_r5: assert property (@(posedge clk) disable iff (rst)
      (lane_o[g*GRP_LANES +: GRP_LANES] == '0) ||
      (lane_o[g*GRP_LANES +: GRP_LANES] == '1));
  end
endmodule

// File: tb/sim_mlane_pkt_tx.sv
module sim_mlane_pkt_tx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pkt_start = 1'b0;
  logic [7:0] gap_a = '0;
  logic [7:0] gap_b = '0;
  logic [7:0] lane_o;
  logic [1:0] busy_o;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  bit qa[$];
  bit qb[$];
  int unsigned seq_m = 0;
  bit exp_lane [2];
  bit exp_busy [2];

  always #4 clk = ~clk;

  mlane_pkt_tx u0 (
    .clk(clk), .rst(rst), .pkt_start(pkt_start),
    .gap_a(gap_a), .gap_b(gap_b), .lane_o(lane_o), .busy_o(busy_o)
  );

  function automatic void push_lvl(int g, bit v);
    if (g == 0) qa.push_back(v);
    else qb.push_back(v);
  endfunction

  function automatic void push_pkt(int g, int unsigned s, int gap);
    bit [43:0] p;
    bit [7:0] x;
    x = s[31:24] ^ s[23:16] ^ s[15:8] ^ s[7:0];
    p = {4'b1010, s, x};
    for (int i = 43; i >= 0; i--) begin
      push_lvl(g, !p[i]);
      push_lvl(g, p[i]);
    end
    for (int i = 0; i < 2 * gap; i++) push_lvl(g, 1'b0);
  endfunction

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    bit acc [2];
    int sz [2];
    @(posedge clk);
    sz[0] = qa.size();
    sz[1] = qb.size();
    for (int g = 0; g < 2; g++) begin
      acc[g] = pkt_start && (sz[g] <= 1);
      exp_lane[g] = 1'b0;
      if (sz[g] > 0) begin
        if (g == 0) exp_lane[g] = qa.pop_front();
        else exp_lane[g] = qb.pop_front();
      end
    end
    if (acc[0]) push_pkt(0, seq_m, int'(gap_a));
    if (acc[1]) push_pkt(1, seq_m, int'(gap_b));
    if (acc[0] || acc[1]) seq_m++;
    exp_busy[0] = (qa.size() > 0);
    exp_busy[1] = (qb.size() > 0);
    #1;
    for (int g = 0; g < 2; g++) begin
      check(cur_req, $sformatf("lane group %0d", g), int'(lane_o[g*4]), int'(exp_lane[g]));
      check("R9", $sformatf("busy group %0d", g), int'(busy_o[g]), int'(exp_busy[g]));
      // R5: four lanes of one group identical
      check("R5", $sformatf("lane agreement group %0d", g),
            int'(lane_o[g*4 +: 4] == 4'h0 || lane_o[g*4 +: 4] == 4'hf), 1);
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic drain();
    pkt_start = 1'b0;
    while (qa.size() > 0 || qb.size() > 0) tick();
    run(2);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    check("R1", "lanes in reset", int'(lane_o), 0);
    check("R1", "busy in reset", int'(busy_o), 0);
    rst = 1'b0;
    cur_req = "R1";
    tick();

    // R2 / R3: one packet on both groups, different gaps
    cur_req = "R3";
    gap_a = 8'd2; gap_b = 8'd6;
    pkt_start = 1'b1;
    tick();
    pkt_start = 1'b0;
    cur_req = "R2";
    drain();

    // R4: periodic triggers, groups accept at different times
    cur_req = "R4";
    gap_a = 8'd0; gap_b = 8'd40;
    for (int k = 0; k < 8; k++) begin
      pkt_start = 1'b1;
      tick();
      pkt_start = 1'b0;
      run(95);
    end
    drain();

    // R6: trigger held high while busy, gaps respected
    cur_req = "R6";
    gap_a = 8'd3; gap_b = 8'd10;
    pkt_start = 1'b1;
    run(400);
    drain();

    // R7: zero gap, back-to-back
    cur_req = "R7";
    gap_a = 8'd0; gap_b = 8'd0;
    pkt_start = 1'b1;
    run(300);
    drain();

    // R8: spacing changes mid-packet have no effect
    cur_req = "R8";
    gap_a = 8'd5; gap_b = 8'd1;
    pkt_start = 1'b1;
    tick();
    pkt_start = 1'b0;
    for (int i = 0; i < 40; i++) begin
      gap_a = 8'(i * 7);
      gap_b = 8'(255 - i);
      tick();
    end
    gap_a = 8'd9; gap_b = 8'd9;
    drain();

    // R9: trigger arriving exactly at end of gap and just after idle
    cur_req = "R9";
    gap_a = 8'd1; gap_b = 8'd2;
    pkt_start = 1'b1;
    tick();
    pkt_start = 1'b0;
    run(88);
    pkt_start = 1'b1;
    run(3);
    pkt_start = 1'b0;
    drain();

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule